// File: doc/BRIEF.md
# Byte-Parity Registered Bidirectional Transceiver

This block carries a 16-bit word, with one parity bit per byte, between an A side and a B side. Each direction has its own storage stage, latch enable, clock and active-low output enable. The stage can pass data straight through, hold a captured value, or take a new value on each rising edge of its clock. Data and parity always travel through the stage together.

The A-to-B direction can generate fresh parity or check the parity that arrives with the data. The B-to-A direction can only check. Each direction has one active-low error flag that covers both bytes. A single select sets the parity sense for both directions. Tri-state buses are modelled as a value plus a drive enable. An open-drain error flag is modelled as a pull-low enable, and the system resolves it through a pull-up.

Top module: `parity_xcvr`

## Requirements
- R1: When a direction's latch enable is 1, its data and parity outputs follow its inputs combinationally, with no clock edge needed.
- R2: When the latch enable is 0, the outputs show the value the stage took at the most recent rising edge of that direction's clock, and they hold it while no edge occurs. The stage also loads on every edge while the latch enable is 1.
- R3: Output enables are active low. When an enable is 1, that direction's bus drive enable is 0 and its error pull-low enable is 0. When an enable is 0, the bus drive enable is 1.
- R4: Parity bit index 0 covers data bits 7:0, and parity bit index 1 covers data bits 15:8.
- R5: In A-to-B generate mode (`gen_mode`=1) with `parity_odd`=0, each output parity bit is 1 when its byte has an odd number of ones. With `parity_odd`=1 the bit is inverted.
- R6: In generate mode the `a_par_i` value has no effect on any A-to-B output.
- R7: In check mode the output parity bits equal the input parity bits, whether or not an error is found.
- R8: In check mode with `parity_odd`=0, a byte is in error when its 9-bit group (byte plus parity) has an odd number of ones. With `parity_odd`=1, a byte is in error when the group has an even number of ones.
- R9: A direction's error pull-low enable is 1 when either byte is in error and the output enable is 0. It is always 0 for A-to-B while A-to-B is in generate mode.
- R10: B-to-A always checks, whatever the value of `gen_mode`. `parity_odd` applies to both directions.
- R11: The error flag uses the same stage timing as the data: it is transparent when the latch enable is 1, and it is updated at the clock edge when the latch enable is 0.
- R12: While `rst_n` is 0, the stored data, parity and error state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B stage clock (rising edge) |
| clk_ba | input | 1 | B-to-A stage clock (rising edge) |
| rst_n | input | 1 | Asynchronous active-low clear of both stages |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| gen_mode | input | 1 | 1 = A-to-B generates parity, 0 = A-to-B checks |
| parity_odd | input | 1 | Parity sense for both directions, 0 = even, 1 = odd |
| a_data_i | input | 16 | A-side data seen by the A-to-B path |
| a_par_i | input | 2 | A-side parity seen by the A-to-B path |
| a_data_o | output | 16 | A-side data driven by the B-to-A path |
| a_par_o | output | 2 | A-side parity driven by the B-to-A path |
| a_drive | output | 1 | Drive enable for the A-side data and parity |
| b_data_i | input | 16 | B-side data seen by the B-to-A path |
| b_par_i | input | 2 | B-side parity seen by the B-to-A path |
| b_data_o | output | 16 | B-side data driven by the A-to-B path |
| b_par_o | output | 2 | B-side parity driven by the A-to-B path |
| b_drive | output | 1 | Drive enable for the B-side data and parity |
| err_ab_pull | output | 1 | Pull-low enable of the A-to-B error flag |
| err_ba_pull | output | 1 | Pull-low enable of the B-to-A error flag |

## Verification
In transparent mode every result is due in the same cycle as the stimulus. The bench drives inputs on a falling edge and samples 1 ns later. In stored mode a result is due only after the next rising edge of that direction's clock. The bench first confirms the old value is still present before that edge, then samples 1 ns after the edge. Hold behaviour is checked by gating the direction's clock off for several cycles while the inputs change, then confirming the outputs have not moved.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
   // Picks the parity variant built into one direction of the transceiver
   typedef enum logic {
      DIR_GEN_OR_CHECK = 1'b0,
      DIR_CHECK_ONLY   = 1'b1
   } dir_kind_e;

   localparam int unsigned DEF_BYTE_W  = 8;
   localparam int unsigned DEF_N_BYTES = 2;
endpackage

// File: rtl/byte_parity_unit.sv
`timescale 1ns/1ps
module byte_parity_unit #(
   parameter int unsigned         BYTE_W  = xcvr_pkg::DEF_BYTE_W,
   parameter int unsigned         N_BYTES = xcvr_pkg::DEF_N_BYTES,
   parameter xcvr_pkg::dir_kind_e KIND    = xcvr_pkg::DIR_GEN_OR_CHECK
) (
   input  logic [BYTE_W*N_BYTES-1:0] data_i,
   input  logic [N_BYTES-1:0]        par_i,
   input  logic                      gen_i,
   input  logic                      odd_i,
   output logic [N_BYTES-1:0]        par_o,
   output logic                      err_o
);
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("byte_parity_unit: BYTE_W must be at least 1");
   end
   if (N_BYTES < 1) begin : g_bad_n_bytes
      $error("byte_parity_unit: N_BYTES must be at least 1");
   end

   // A check-only direction folds the generate select to a constant 0
   logic gen_eff;
   assign gen_eff = (KIND == xcvr_pkg::DIR_GEN_OR_CHECK) && gen_i;

   logic [N_BYTES-1:0] byte_red;
   logic [N_BYTES-1:0] byte_bad;

   for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
      assign byte_red[k] = ^data_i[k*BYTE_W +: BYTE_W];
      assign par_o[k]    = gen_eff ? (byte_red[k] ^ odd_i) : par_i[k];
      assign byte_bad[k] = !gen_eff && (byte_red[k] ^ par_i[k] ^ odd_i);
   end

   assign err_o = |byte_bad;
endmodule

// File: rtl/hold_stage.sv
`timescale 1ns/1ps
module hold_stage #(
   parameter int unsigned W = 19
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         le_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("hold_stage: W must be at least 1");
   end

   logic [W-1:0] held_q;

   // Loads on every edge, so dropping le_i keeps the last captured word
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) held_q <= '0;
      else          held_q <= d_i;
   end

   assign q_o = le_i ? d_i : held_q;

   AST_STAGE_SHOWS_LAST_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($past(rst_n_i) && !le_i) |-> (q_o == $past(d_i))); // R2
endmodule

// File: rtl/xfer_path.sv
`timescale 1ns/1ps
module xfer_path #(
   parameter int unsigned         BYTE_W  = xcvr_pkg::DEF_BYTE_W,
   parameter int unsigned         N_BYTES = xcvr_pkg::DEF_N_BYTES,
   parameter xcvr_pkg::dir_kind_e KIND    = xcvr_pkg::DIR_GEN_OR_CHECK
) (
   input  logic                      clk_i,
   input  logic                      rst_n_i,
   input  logic                      le_i,
   input  logic                      oe_n_i,
   input  logic                      gen_i,
   input  logic                      odd_i,
   input  logic [BYTE_W*N_BYTES-1:0] data_i,
   input  logic [N_BYTES-1:0]        par_i,
   output logic [BYTE_W*N_BYTES-1:0] data_o,
   output logic [N_BYTES-1:0]        par_o,
   output logic                      drive_o,
   output logic                      err_pull_o
);
   localparam int unsigned DATA_W = BYTE_W * N_BYTES;
   localparam int unsigned STG_W  = DATA_W + N_BYTES + 1;
   localparam int unsigned ERR_IX = STG_W - 1;

   logic [N_BYTES-1:0] par_next;
   logic               err_next;
   logic [STG_W-1:0]   stg_d;
   logic [STG_W-1:0]   stg_q;

   byte_parity_unit #(
      .BYTE_W (BYTE_W),
      .N_BYTES(N_BYTES),
      .KIND   (KIND)
   ) u_parity (
      .data_i(data_i),
      .par_i (par_i),
      .gen_i (gen_i),
      .odd_i (odd_i),
      .par_o (par_next),
      .err_o (err_next)
   );

   // Data, parity and error flag share one stage so they always move together
   assign stg_d = {err_next, par_next, data_i};

   hold_stage #(.W(STG_W)) u_stage (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .le_i   (le_i),
      .d_i    (stg_d),
      .q_o    (stg_q)
   );

   assign data_o     = stg_q[DATA_W-1:0];
   assign par_o      = stg_q[DATA_W +: N_BYTES];
   assign drive_o    = !oe_n_i;
   assign err_pull_o = !oe_n_i && stg_q[ERR_IX];

   AST_RELEASED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      oe_n_i |-> (!drive_o && !err_pull_o)); // R3

   AST_CHECK_FORWARDS_PARITY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (le_i && ((KIND == xcvr_pkg::DIR_CHECK_ONLY) || !gen_i)) |-> (par_o == par_i)); // R7

   if (KIND == xcvr_pkg::DIR_GEN_OR_CHECK) begin : g_gen_checks
      AST_GEN_NEVER_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         (gen_i && le_i) |-> !err_pull_o); // R9
      for (genvar k = 0; k < N_BYTES; k++) begin : g_byte_chk
         AST_GEN_PARITY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (gen_i && le_i) |-> ((^{data_o[k*BYTE_W +: BYTE_W], par_o[k]}) == odd_i)); // R5
      end
   end
endmodule

// File: rtl/parity_xcvr.sv
`timescale 1ns/1ps
module parity_xcvr #(
   parameter int unsigned BYTE_W  = xcvr_pkg::DEF_BYTE_W,
   parameter int unsigned N_BYTES = xcvr_pkg::DEF_N_BYTES
) (
   input  logic                      clk_ab,
   input  logic                      clk_ba,
   input  logic                      rst_n,
   input  logic                      le_ab,
   input  logic                      le_ba,
   input  logic                      oe_ab_n,
   input  logic                      oe_ba_n,
   input  logic                      gen_mode,
   input  logic                      parity_odd,
   input  logic [BYTE_W*N_BYTES-1:0] a_data_i,
   input  logic [N_BYTES-1:0]        a_par_i,
   output logic [BYTE_W*N_BYTES-1:0] a_data_o,
   output logic [N_BYTES-1:0]        a_par_o,
   output logic                      a_drive,
   input  logic [BYTE_W*N_BYTES-1:0] b_data_i,
   input  logic [N_BYTES-1:0]        b_par_i,
   output logic [BYTE_W*N_BYTES-1:0] b_data_o,
   output logic [N_BYTES-1:0]        b_par_o,
   output logic                      b_drive,
   output logic                      err_ab_pull,
   output logic                      err_ba_pull
);
   if (BYTE_W * N_BYTES > 1024) begin : g_bad_total
      $error("parity_xcvr: word wider than 1024 bits");
   end

   xfer_path #(
      .BYTE_W (BYTE_W),
      .N_BYTES(N_BYTES),
      .KIND   (xcvr_pkg::DIR_GEN_OR_CHECK)
   ) u_a2b (
      .clk_i     (clk_ab),
      .rst_n_i   (rst_n),
      .le_i      (le_ab),
      .oe_n_i    (oe_ab_n),
      .gen_i     (gen_mode),
      .odd_i     (parity_odd),
      .data_i    (a_data_i),
      .par_i     (a_par_i),
      .data_o    (b_data_o),
      .par_o     (b_par_o),
      .drive_o   (b_drive),
      .err_pull_o(err_ab_pull)
   );

   xfer_path #(
      .BYTE_W (BYTE_W),
      .N_BYTES(N_BYTES),
      .KIND   (xcvr_pkg::DIR_CHECK_ONLY)
   ) u_b2a (
      .clk_i     (clk_ba),
      .rst_n_i   (rst_n),
      .le_i      (le_ba),
      .oe_n_i    (oe_ba_n),
      .gen_i     (gen_mode),
      .odd_i     (parity_odd),
      .data_i    (b_data_i),
      .par_i     (b_par_i),
      .data_o    (a_data_o),
      .par_o     (a_par_o),
      .drive_o   (a_drive),
      .err_pull_o(err_ba_pull)
   );
endmodule

// File: tb/parity_xcvr_tb_top.sv
`timescale 1ns/1ps
module parity_xcvr_tb_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic run_ab = 1'b1, run_ba = 1'b1;
   logic clk_ab, clk_ba;
   assign clk_ab = clk & run_ab;
   assign clk_ba = clk & run_ba;

   logic        rst_n = 1'b0;
   logic        le_ab = 1'b0, le_ba = 1'b0, oe_ab_n = 1'b0, oe_ba_n = 1'b0;
   logic        gen_mode = 1'b0, parity_odd = 1'b0;
   logic [15:0] a_data_i = 16'h5A5A, b_data_i = 16'hA5A5;
   logic [1:0]  a_par_i = 2'b11, b_par_i = 2'b11;
   logic [15:0] a_data_o, b_data_o;
   logic [1:0]  a_par_o, b_par_o;
   logic        a_drive, b_drive, err_ab_pull, err_ba_pull;

   parity_xcvr dut_i (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
      .le_ab(le_ab), .le_ba(le_ba), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
      .gen_mode(gen_mode), .parity_odd(parity_odd),
      .a_data_i(a_data_i), .a_par_i(a_par_i),
      .a_data_o(a_data_o), .a_par_o(a_par_o), .a_drive(a_drive),
      .b_data_i(b_data_i), .b_par_i(b_par_i),
      .b_data_o(b_data_o), .b_par_o(b_par_o), .b_drive(b_drive),
      .err_ab_pull(err_ab_pull), .err_ba_pull(err_ba_pull)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // {gen_mode, parity_odd, a_data[15:0], a_par[1:0], exp_par[1:0], exp_err}
   localparam logic [22:0] VEC [0:9] = '{
      {1'b1, 1'b0, 16'h0000, 2'b11, 2'b00, 1'b0},
      {1'b1, 1'b0, 16'h0301, 2'b00, 2'b01, 1'b0},
      {1'b1, 1'b1, 16'h0301, 2'b00, 2'b10, 1'b0},
      {1'b1, 1'b0, 16'hFF7F, 2'b10, 2'b01, 1'b0},
      {1'b0, 1'b0, 16'h0301, 2'b01, 2'b01, 1'b0},
      {1'b0, 1'b0, 16'h0301, 2'b00, 2'b00, 1'b1},
      {1'b0, 1'b0, 16'h0301, 2'b11, 2'b11, 1'b1},
      {1'b0, 1'b1, 16'h0301, 2'b10, 2'b10, 1'b0},
      {1'b0, 1'b1, 16'h0301, 2'b01, 2'b01, 1'b1},
      {1'b0, 1'b1, 16'hA5C3, 2'b11, 2'b11, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12: reset clears the stage, seen with le low
      repeat (3) @(negedge clk);
      #1;
      check("R12", "b_data_o in reset", 32'(b_data_o), 32'h0);
      check("R12", "b_par_o in reset", 32'(b_par_o), 32'h0);
      check("R12", "err_ab_pull in reset", 32'(err_ab_pull), 32'h0);
      check("R12", "a_data_o in reset", 32'(a_data_o), 32'h0);
      check("R12", "err_ba_pull in reset", 32'(err_ba_pull), 32'h0);
      check("R3", "b_drive with oe low", 32'(b_drive), 32'h1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R5 / R6 / R7 / R8 / R9: transparent table walk
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         le_ab      = 1'b1;
         gen_mode   = VEC[i][22];
         parity_odd = VEC[i][21];
         a_data_i   = VEC[i][20:5];
         a_par_i    = VEC[i][4:3];
         #1;
         check("R1", $sformatf("row %0d data", i), 32'(b_data_o), 32'(VEC[i][20:5]));
         check(VEC[i][22] ? "R5" : "R7", $sformatf("row %0d parity", i),
               32'(b_par_o), 32'(VEC[i][2:1]));
         check(VEC[i][22] ? "R9" : "R8", $sformatf("row %0d error", i),
               32'(err_ab_pull), 32'(VEC[i][0]));
      end

      // R6: same data, other parity input, same generated parity
      @(negedge clk);
      gen_mode = 1'b1; parity_odd = 1'b0; a_data_i = 16'h0301; a_par_i = 2'b11;
      #1;
      check("R6", "gen ignores a_par_i", 32'(b_par_o), 32'h1);

      // R4: only the high byte holds a one, so only parity index 1 is set
      @(negedge clk);
      a_data_i = 16'h0100; a_par_i = 2'b00;
      #1;
      check("R4", "high byte maps to parity index 1", 32'(b_par_o), 32'h2);

      // R3: disabled output releases bus and flag
      @(negedge clk);
      gen_mode = 1'b0; a_data_i = 16'h0301; a_par_i = 2'b00; oe_ab_n = 1'b1;
      #1;
      check("R3", "b_drive when disabled", 32'(b_drive), 32'h0);
      check("R3", "err_ab_pull when disabled", 32'(err_ab_pull), 32'h0);
      @(negedge clk);
      oe_ab_n = 1'b0;
      #1;
      check("R9", "err_ab_pull re-enabled", 32'(err_ab_pull), 32'h1);

      // R10: B-to-A checks even with gen_mode=1; parity_odd is shared
      @(negedge clk);
      gen_mode = 1'b1; parity_odd = 1'b0; le_ba = 1'b1;
      b_data_i = 16'h0301; b_par_i = 2'b00;
      #1;
      check("R10", "a_data_o transparent", 32'(a_data_o), 32'h0301);
      check("R10", "a_par_o forwarded", 32'(a_par_o), 32'h0);
      check("R10", "err_ba_pull in check", 32'(err_ba_pull), 32'h1);
      @(negedge clk);
      parity_odd = 1'b1; b_par_i = 2'b10;
      #1;
      check("R10", "err_ba_pull with odd sense", 32'(err_ba_pull), 32'h0);
      @(negedge clk);
      oe_ba_n = 1'b1;
      #1;
      check("R3", "a_drive when disabled", 32'(a_drive), 32'h0);

      // R2: stage loads while le high, then holds after le falls
      @(negedge clk);
      gen_mode = 1'b0; parity_odd = 1'b0;
      le_ab = 1'b1; a_data_i = 16'h0F0F; a_par_i = 2'b00;
      @(negedge clk);
      le_ab = 1'b0; a_data_i = 16'hFFFF;
      #1;
      check("R2", "holds value from last edge", 32'(b_data_o), 32'h0F0F);
      @(negedge clk);
      a_data_i = 16'h1234; a_par_i = 2'b00;
      #1;
      check("R2", "before edge shows old word", 32'(b_data_o), 32'hFFFF);
      @(posedge clk);
      #1;
      check("R2", "captured at edge", 32'(b_data_o), 32'h1234);
      check("R11", "error stored at edge", 32'(err_ab_pull), 32'h1);
      check("R7", "stored parity forwarded", 32'(b_par_o), 32'h0);

      // R2: no edge, no change
      @(negedge clk);
      run_ab = 1'b0; a_data_i = 16'hFFFF; a_par_i = 2'b00;
      repeat (3) @(negedge clk);
      #1;
      check("R2", "holds with clock stopped", 32'(b_data_o), 32'h1234);
      check("R11", "error held with clock stopped", 32'(err_ab_pull), 32'h1);
      @(negedge clk);
      run_ab = 1'b1;
      @(posedge clk);
      #1;
      check("R2", "captures after restart", 32'(b_data_o), 32'hFFFF);
      check("R11", "error cleared at edge", 32'(err_ab_pull), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule